// File: doc/BRIEF.md
# GPIO Port with Pin Interrupt Detector

This block is one 32-pin general-purpose I/O port that sits behind a plain 32-bit register bus. Each pin has its own output-enable, input-enable and drive-value bit. The pad drivers take their value and enable straight from these bits. The pad levels come back through a two-flop synchroniser that advances only on a chosen sample strobe. The register bus reads back the synchronised level of each pin.

Every pin also has an interrupt detector. It can be set to one of four trigger types: level high, level low, rising edge or falling edge. Detected events set a per-pin pending bit, and software clears that bit by writing 1 to it. A port control register holds three bits: a global interrupt enable, a sticky port-level pending flag and the choice of sample strobe. The single interrupt line rises when the port is enabled and at least one pending pin is unmasked. There is no native dual-edge mode. Software emulates it by flipping the trigger type between rising and falling.

The bus uses word addresses (`bus_addr` counts 32-bit words). A write happens in the cycle where `bus_we` is high. Read data is a combinational function of `bus_addr` and the current register state.

Top module: `gpio_irq_port`

## Requirements
- R1: After synchronous reset, every register reads 0, `pad_oe` and `pad_out` are 0, and `irq` is 0. The trigger type resets to level high.
- R2: Word 0 is output enable, word 1 is input enable and word 2 is drive data. Bit n of each belongs to pin n. `pad_oe` and `pad_out` show a write one cycle after it.
- R3: Reading word 2 returns the following for bit n. If input enable n is set, it is the synchronised level of pin n. Otherwise, if output enable n is set, it is the driven value. Otherwise it is 0.
- R4: Each trigger-type field is 2 bits, with pin p at bits [2*(p%16)+1 : 2*(p%16)]. Pins 0-15 live in word 7 and pins 16-31 live in word 6. The encoding is 00 level high, 01 level low, 10 rising, 11 falling.
- R5: An edge type sets the pin's pending bit once per matching transition of the synchronised level. The opposite transition sets nothing.
- R6: A level type sets the pending bit again on every sample while the level matches, even right after a clear.
- R7: Word 5 holds the per-pin pending bits. Writing 1 to bit n clears it and writing 0 has no effect. An event in the same cycle as a clear wins.
- R8: A pin whose input-enable bit is 0 never raises an event.
- R9: Bit 2 of the control word (word 3) selects the sample strobe: 1 selects `tick_fast` and 0 selects `tick_slow`. The synchroniser and the detector advance only on the selected strobe.
- R10: `irq` is high exactly when control bit 0 is set and some pending bit has its mask bit set. The mask is word 4, with 1 enabling the pin.
- R11: Control bit 1 is a sticky flag. It sets when an event latches on a pin whose mask bit is 1. Writing 1 to it clears it, and writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tick_fast | input | 1 | Fast sample strobe |
| tick_slow | input | 1 | Slow sample strobe |
| pad_in | input | 32 | Pad levels |
| pad_out | output | 32 | Pad drive values |
| pad_oe | output | 32 | Pad output enables |
| irq | output | 1 | Port interrupt request |

## Verification
The hardest case to reach is a clear that collides with a re-set from a level trigger. The pending bit must stay 1 even though software just wrote 1 to it. The bench drives it by holding a pad low under level-low and writing the clear while samples keep arriving. A second hard case is the slow strobe. With `tick_slow` held low, an edge must stay invisible for many cycles, and it must only appear once the bench pulses the strobe by hand. A behavioural model runs every cycle alongside these directed checks and catches any off-by-one in the synchroniser latency.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int N_PINS   = 32;
    localparam int DW       = 32;
    localparam int AW       = 3;
    localparam int HALF     = N_PINS / 2;
    localparam int TYPE_W   = 2;

    typedef enum logic [1:0] {
        TRIG_LVL_HI = 2'b00,
        TRIG_LVL_LO = 2'b01,
        TRIG_RISE   = 2'b10,
        TRIG_FALL   = 2'b11
    } trig_e;

    typedef enum logic [AW-1:0] {
        REG_OE       = 3'd0,
        REG_IEN      = 3'd1,
        REG_DATA     = 3'd2,
        REG_CTRL     = 3'd3,
        REG_MASK     = 3'd4,
        REG_PEND     = 3'd5,
        REG_TYPE_UP  = 3'd6,
        REG_TYPE_LOW = 3'd7
    } reg_sel_e;

    // bit 0 enable, bit 1 sticky pending, bit 2 fast sample select
    typedef struct packed {
        logic samp_fast;
        logic port_pend;
        logic irq_en;
    } ctrl_t;

    typedef logic [N_PINS-1:0][TYPE_W-1:0] type_vec_t;

    function automatic logic trig_hit(trig_e t, logic cur, logic prev);
        case (t)
            TRIG_LVL_HI: return cur;
            TRIG_LVL_LO: return !cur;
            TRIG_RISE:   return cur & !prev;
            default:     return !cur & prev;
        endcase
    endfunction
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_tick,
    input  logic [N_PINS-1:0] pin_i,
    output logic [N_PINS-1:0] lvl_o,
    output logic [N_PINS-1:0] prev_o,
    output logic              smp_valid_o
);
    logic [N_PINS-1:0] meta_q, lvl_q, prev_q;
    logic              valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q  <= '0;
            lvl_q   <= '0;
            prev_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= smp_tick;
            if (smp_tick) begin
                meta_q <= pin_i;
                lvl_q  <= meta_q;
                prev_q <= lvl_q;
            end
        end
    end

    assign lvl_o       = lvl_q;
    assign prev_o      = prev_q;
    assign smp_valid_o = valid_q;

    // R9
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_tick |=> $stable(lvl_q));
endmodule

// File: rtl/gpio_port_detect.sv
module gpio_port_detect
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid_i,
    input  logic [N_PINS-1:0] lvl_i,
    input  logic [N_PINS-1:0] prev_i,
    input  logic [N_PINS-1:0] ien_i,
    input  logic [N_PINS-1:0] mask_i,
    input  type_vec_t         type_i,
    input  logic [N_PINS-1:0] clr_i,
    output logic [N_PINS-1:0] pend_o,
    output logic              port_set_o
);
    logic [N_PINS-1:0] evt;
    logic [N_PINS-1:0] pend_q;

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        assign evt[g] = smp_valid_i & ien_i[g]
                      & trig_hit(trig_e'(type_i[g]), lvl_i[g], prev_i[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr_i) | evt;
    end

    assign pend_o     = pend_q;
    assign port_set_o = |(evt & mask_i);

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((pend_q & $past(evt)) == $past(evt)));
    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (|(clr_i & ~evt)) |=> ((pend_q & $past(clr_i & ~evt)) == '0));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic [N_PINS-1:0] lvl_i,
    input  logic [N_PINS-1:0] pend_i,
    input  logic              port_set_i,
    output logic [N_PINS-1:0] oe_o,
    output logic [N_PINS-1:0] ien_o,
    output logic [N_PINS-1:0] dout_o,
    output logic [N_PINS-1:0] mask_o,
    output type_vec_t         type_o,
    output ctrl_t             ctrl_o,
    output logic [N_PINS-1:0] pend_clr_o,
    output logic [DW-1:0]     rdata_o
);
    reg_sel_e          sel;
    logic [N_PINS-1:0] oe_q, ien_q, dout_q, mask_q;
    type_vec_t         type_q;
    ctrl_t             ctrl_q;
    logic              ctrl_wr;
    logic [N_PINS-1:0] readback;

    assign sel     = reg_sel_e'(addr_i);
    assign ctrl_wr = we_i && (sel == REG_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q   <= '0;
            ien_q  <= '0;
            dout_q <= '0;
            mask_q <= '0;
            type_q <= '0;
            ctrl_q <= '0;
        end else begin
            ctrl_q.port_pend <= port_set_i
                              | (ctrl_q.port_pend & ~(ctrl_wr & wdata_i[1]));
            if (we_i) begin
                case (sel)
                    REG_OE:       oe_q   <= wdata_i;
                    REG_IEN:      ien_q  <= wdata_i;
                    REG_DATA:     dout_q <= wdata_i;
                    REG_CTRL: begin
                        ctrl_q.irq_en    <= wdata_i[0];
                        ctrl_q.samp_fast <= wdata_i[2];
                    end
                    REG_MASK:     mask_q <= wdata_i;
                    REG_TYPE_UP:  type_q[N_PINS-1:HALF] <= wdata_i;
                    REG_TYPE_LOW: type_q[HALF-1:0]      <= wdata_i;
                    default: ;
                endcase
            end
        end
    end

    assign pend_clr_o = (we_i && sel == REG_PEND) ? wdata_i : '0;
    assign readback   = (ien_q & lvl_i) | (~ien_q & oe_q & dout_q);

    always_comb begin
        case (sel)
            REG_OE:       rdata_o = oe_q;
            REG_IEN:      rdata_o = ien_q;
            REG_DATA:     rdata_o = readback;
            REG_CTRL:     rdata_o = {{(DW-3){1'b0}}, ctrl_q};
            REG_MASK:     rdata_o = mask_q;
            REG_PEND:     rdata_o = pend_i;
            REG_TYPE_UP:  rdata_o = type_q[N_PINS-1:HALF];
            default:      rdata_o = type_q[HALF-1:0];
        endcase
    end

    assign oe_o   = oe_q;
    assign ien_o  = ien_q;
    assign dout_o = dout_q;
    assign mask_o = mask_q;
    assign type_o = type_q;
    assign ctrl_o = ctrl_q;

    // R2
    oe_write_chk: assert property (@(posedge clk) disable iff (rst)
        (we_i && sel == REG_OE) |=> (oe_q == $past(wdata_i)));
    // R11
    port_pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        port_set_i |=> ctrl_q.port_pend);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              tick_fast,
    input  logic              tick_slow,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe,
    output logic              irq
);
    logic [N_PINS-1:0] lvl, prev, ien, mask, pend, pend_clr, oe, dout;
    type_vec_t         types;
    ctrl_t             ctrl;
    logic              smp_tick, smp_valid, port_set;

    assign smp_tick = ctrl.samp_fast ? tick_fast : tick_slow;

    gpio_port_sync u_sync (
        .clk         (clk),
        .rst         (rst),
        .smp_tick    (smp_tick),
        .pin_i       (pad_in),
        .lvl_o       (lvl),
        .prev_o      (prev),
        .smp_valid_o (smp_valid)
    );

    gpio_port_detect u_detect (
        .clk         (clk),
        .rst         (rst),
        .smp_valid_i (smp_valid),
        .lvl_i       (lvl),
        .prev_i      (prev),
        .ien_i       (ien),
        .mask_i      (mask),
        .type_i      (types),
        .clr_i       (pend_clr),
        .pend_o      (pend),
        .port_set_o  (port_set)
    );

    gpio_port_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .we_i       (bus_we),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .lvl_i      (lvl),
        .pend_i     (pend),
        .port_set_i (port_set),
        .oe_o       (oe),
        .ien_o      (ien),
        .dout_o     (dout),
        .mask_o     (mask),
        .type_o     (types),
        .ctrl_o     (ctrl),
        .pend_clr_o (pend_clr),
        .rdata_o    (bus_rdata)
    );

    assign pad_out = dout;
    assign pad_oe  = oe;
    assign irq     = ctrl.irq_en & |(pend & mask);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (pad_oe == '0 && irq == 1'b0));
    // R10
    irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.irq_en |-> !irq);
endmodule

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_fast = 1'b1;
    logic        tick_slow = 1'b0;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    gpio_irq_port u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_fast(tick_fast),
        .tick_slow(tick_slow), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .irq(irq)
    );

    // behavioural reference state
    bit [31:0] m_oe, m_ien, m_dout, m_mask, m_pend, m_s1, m_s2, m_s3;
    bit [1:0]  m_type [32];
    bit        m_en, m_pp, m_sel, m_tq;

    function automatic bit [31:0] m_read(input int a);
        bit [31:0] r = 0;
        case (a)
            0: r = m_oe;
            1: r = m_ien;
            2: for (int p = 0; p < 32; p++)
                   r[p] = m_ien[p] ? m_s2[p] : (m_oe[p] & m_dout[p]);
            3: r = {29'b0, m_sel, m_pp, m_en};
            4: r = m_mask;
            5: r = m_pend;
            6: for (int p = 0; p < 16; p++) r[2*p +: 2] = m_type[p+16];
            default: for (int p = 0; p < 16; p++) r[2*p +: 2] = m_type[p];
        endcase
        return r;
    endfunction

    task automatic check(input string tag, input bit [31:0] act, input bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_oe = 0; m_ien = 0; m_dout = 0; m_mask = 0; m_pend = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_en = 0; m_pp = 0; m_sel = 0; m_tq = 0;
            for (int p = 0; p < 32; p++) m_type[p] = 0;
        end else begin
            bit [31:0] evt, clr;
            bit tk, hit;
            tk = m_sel ? tick_fast : tick_slow;
            evt = 0;
            for (int p = 0; p < 32; p++) begin
                case (m_type[p])
                    2'd0: hit = m_s2[p];
                    2'd1: hit = !m_s2[p];
                    2'd2: hit = m_s2[p] && !m_s3[p];
                    default: hit = !m_s2[p] && m_s3[p];
                endcase
                evt[p] = m_tq && m_ien[p] && hit;
            end
            clr = (bus_we && bus_addr == 5) ? bus_wdata : 0;
            m_pp = ((evt & m_mask) != 0) || (m_pp && !(bus_we && bus_addr == 3 && bus_wdata[1]));
            m_pend = (m_pend & ~clr) | evt;
            if (bus_we) begin
                case (bus_addr)
                    0: m_oe = bus_wdata;
                    1: m_ien = bus_wdata;
                    2: m_dout = bus_wdata;
                    3: begin m_en = bus_wdata[0]; m_sel = bus_wdata[2]; end
                    4: m_mask = bus_wdata;
                    6: for (int p = 0; p < 16; p++) m_type[p+16] = bus_wdata[2*p +: 2];
                    7: for (int p = 0; p < 16; p++) m_type[p] = bus_wdata[2*p +: 2];
                    default: ;
                endcase
            end
            if (tk) begin m_s3 = m_s2; m_s2 = m_s1; m_s1 = pad_in; end
            m_tq = tk;
        end
        #3;
        if (!rst) begin
            check("R2 pad_out model", pad_out, m_dout);
            check("R2 pad_oe model", pad_oe, m_oe);
            check("R10 irq model", {31'b0, irq}, {31'b0, m_en && ((m_pend & m_mask) != 0)});
            check("R3 rdata model", bus_rdata, m_read(int'(bus_addr)));
        end
    end

    task automatic wr(input bit [2:0] a, input bit [31:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd_chk(input bit [2:0] a, input bit [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1 check(tag, bus_rdata, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        for (int a = 0; a < 8; a++) rd_chk(3'(a), 32'h0, "R1 register reset");
        check("R1 pad_oe", pad_oe, 0);
        check("R1 irq", {31'b0, irq}, 0);
        // R2 drive path
        wr(0, 32'hF0F0_0000);
        wr(2, 32'h1234_5678);
        check("R2 pad_oe", pad_oe, 32'hF0F0_0000);
        check("R2 pad_out", pad_out, 32'h1234_5678);
        // R3 readback mix
        wr(3, 32'h4);
        pad_in = 32'h0000_A5A5;
        wr(1, 32'h0000_FFFF);
        wait_cyc(4);
        rd_chk(2, 32'h1030_A5A5, "R3 data readback");
        wr(1, 32'h0);
        pad_in = 32'h0;
        wait_cyc(4);
        wr(5, 32'hFFFF_FFFF);
        rd_chk(5, 32'h0, "R7 clear all");
        rd_chk(2, 32'h1030_0000, "R3 driven readback");
        // R4 type placement
        wr(7, 32'h0000_0009);
        wr(6, 32'hC000_0000);
        rd_chk(7, 32'h0000_0009, "R4 low pins word");
        rd_chk(6, 32'hC000_0000, "R4 high pins word");
        // R5 edges
        wr(4, 32'h8000_0002);
        wr(3, 32'h5);
        pad_in = 32'h8000_0000;
        wait_cyc(4);
        wr(1, 32'h8000_0002);
        wait_cyc(2);
        wr(5, 32'hFFFF_FFFF);
        wr(3, 32'h7);
        rd_chk(5, 32'h0, "R5 quiet before edge");
        pad_in = 32'h8000_0002;
        wait_cyc(4);
        rd_chk(5, 32'h2, "R5 rising edge");
        check("R10 irq on unmasked pend", {31'b0, irq}, 1);
        rd_chk(3, 32'h7, "R11 port pend set");
        wr(5, 32'h2);
        rd_chk(5, 32'h0, "R7 single clear");
        check("R10 irq after clear", {31'b0, irq}, 0);
        pad_in = 32'h8000_0000;
        wait_cyc(4);
        rd_chk(5, 32'h0, "R5 fall ignored by rising");
        pad_in = 32'h0;
        wait_cyc(4);
        rd_chk(5, 32'h8000_0000, "R5 falling edge");
        // R11 sticky flag
        wr(3, 32'h5);
        rd_chk(3, 32'h7, "R11 zero write keeps");
        wr(3, 32'h7);
        rd_chk(3, 32'h5, "R11 one write clears");
        // R10 gating
        wr(3, 32'h4);
        check("R10 disabled", {31'b0, irq}, 0);
        wr(3, 32'h5);
        check("R10 enabled", {31'b0, irq}, 1);
        wr(4, 32'h2);
        check("R10 masked", {31'b0, irq}, 0);
        wr(5, 32'hFFFF_FFFF);
        // R6 level low on pin 0
        wr(1, 32'h1);
        wait_cyc(4);
        rd_chk(5, 32'h1, "R6 level low");
        wr(5, 32'h1);
        rd_chk(5, 32'h1, "R6 level re-set after clear");
        pad_in = 32'h1;
        wait_cyc(4);
        wr(5, 32'h1);
        wait_cyc(2);
        rd_chk(5, 32'h0, "R6 level released");
        wr(7, 32'h0000_0008);
        wait_cyc(3);
        rd_chk(5, 32'h1, "R6 level high");
        wr(1, 32'h0);
        wait_cyc(2);
        wr(5, 32'h0);
        rd_chk(5, 32'h1, "R7 zero write no effect");
        wr(5, 32'h1);
        rd_chk(5, 32'h0, "R7 clear bit");
        // R8 input enable gate
        wr(7, 32'h0000_0808);
        pad_in = 32'h21;
        wait_cyc(4);
        rd_chk(5, 32'h0, "R8 disabled pin silent");
        // R9 slow strobe
        wr(3, 32'h1);
        wr(1, 32'h2);
        pad_in = 32'h23;
        wait_cyc(10);
        rd_chk(5, 32'h0, "R9 no slow tick");
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); tick_slow = 1;
            @(negedge clk); tick_slow = 0;
            wait_cyc(1);
        end
        wait_cyc(2);
        rd_chk(5, 32'h2, "R9 slow tick edge");
        check("R10 irq slow path", {31'b0, irq}, 1);
        wait_cyc(2);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule